// File: doc/BRIEF.md
# Two-Channel Serial Controller Host Register Unit

This unit sits between a CPU bus and the two serial channels of a dual asynchronous serial controller. It decodes a three-bit register address, a channel-select line, an active-low chip select and active-low read and write strobes. It then steers each access to one of two identical channel register banks. Each channel owns a line control byte, a 16-bit baud divisor split into a low and a high byte, and a function-select byte. Every other register of the channel is held outside this unit. For those registers it emits a one-cycle read or write strobe, and on reads it forwards the value they present.

The top bit of the line control byte is the bank bit. While it is set, addresses 0, 1 and 2 reach the divisor low byte, the divisor high byte and the function-select byte. While it is clear, those addresses go to the outside registers. Each channel divides the system clock by its divisor to produce a 16x baud pulse for its receiver. The channel also drives one multi-function output pin. Two bits of the function-select byte choose whether that pin carries the OUT2 modem control level, the baud pulse or the receive-ready indication.

Top module: `dual_uart_regif`

## Requirements
- R1: When `chan_sel` is 1, the access goes to channel 1, which uses index 0 of every per-channel vector. When `chan_sel` is 0, it goes to channel 2, which uses index 1. Writes to one channel leave the other channel's registers unchanged.
- R2: Bit 7 of a channel's line control byte is the bank bit. With the bank bit at 1, addresses 0, 1 and 2 read and write the divisor low byte, the divisor high byte and the function-select byte. With the bank bit at 0, those addresses reach the outside registers, and reads return `ext_rdata`. Address 3 is always the line control byte.
- R3: Nothing is read or written while `cs_n` is 1. `rdata` is 0 whenever no read is in progress.
- R4: An access to an outside register produces exactly one strobe for one cycle, on its first active cycle, even if the strobe is held longer. The strobe is raised at bit `ch*8+addr` of `ext_wr_stb` or `ext_rd_stb`. An outside register is one at address 0 to 2 with the bank bit at 0, or at address 4 to 7. Accesses to the line control, divisor and function-select bytes raise no strobe.
- R5: When the read and write strobes are both low under chip select, the write is performed. The read is suppressed: `rdata` stays 0 and no read strobe is raised.
- R6: Function-select bits 2:1 drive `mf`. Code 00 selects `out2_n`, 01 selects the baud pulse, 10 selects `rxrdy_n`, and 11 is treated as 00.
- R7: Reset clears the line control byte and the function-select byte, so `mf` shows `out2_n`. The divisor bytes keep their values through reset.
- R8: With divisor D = {high, low}, `baud16` is a one-cycle high pulse every D cycles. A write to either divisor byte restarts the count, so the first pulse falls in the D-th cycle after the writing edge. D = 1 keeps `baud16` high, and D = 0 keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the baud reference |
| rst_n | input | 1 | Synchronous active-low master reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| chan_sel | input | 1 | 1 = channel 1 (index 0), 0 = channel 2 (index 1) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read |
| ext_rdata | input | 128 | Outside register values, byte at (ch*8+addr) |
| ext_wr_stb | output | 16 | One-cycle write strobes for outside registers |
| ext_rd_stb | output | 16 | One-cycle read strobes for outside registers |
| out2_n | input | 2 | OUT2 level per channel |
| rxrdy_n | input | 2 | Receive-ready level per channel |
| lcr_q | output | 16 | Line control byte per channel |
| baud16 | output | 2 | 16x baud pulse per channel |
| mf | output | 2 | Multi-function pin per channel |

## Verification
The two functions that can land in the same cycle are a CPU read and a CPU write. They collide when both strobes are driven low together under chip select. The bench provokes this on the line control byte and judges it at the ports: in that cycle `rdata` must be 0 and no read strobe may appear, and a later read must show the written value. A second overlap is a divisor write that lands while the baud counter is running. It is judged by the position of the first `baud16` pulse after the write.

// File: rtl/dual_uart_regif_pkg.sv
// Package: shared constants and types for the dual-channel host register unit.
// Assumes exactly two channels, picked by a single select line.
package dual_uart_regif_pkg;
    localparam int NCH      = 2;
    localparam int CH_W     = 1;
    localparam int BANK_BIT = 7;
    localparam int ADDR_LO  = 0;
    localparam int ADDR_HI  = 1;
    localparam int ADDR_FSEL = 2;
    localparam int ADDR_LINE = 3;
    localparam int FSEL_LSB = 1;

    // Destination of one host access
    typedef enum logic [2:0] {
        TGT_EXT  = 3'd0,
        TGT_LINE = 3'd1,
        TGT_DLO  = 3'd2,
        TGT_DHI  = 3'd3,
        TGT_FSEL = 3'd4
    } tgt_e;

    // Multi-function pin source codes
    typedef enum logic [1:0] {
        MF_OUT2  = 2'b00,
        MF_BAUD  = 2'b01,
        MF_RXRDY = 2'b10,
        MF_ALT   = 2'b11
    } mf_sel_e;
endpackage

// File: rtl/uart_host_decode.sv
// Module: host access decoder.
// Detects the first cycle of each read or write under chip select and finds
// the addressed channel and the target register, using that channel's bank bit.
// It raises one-cycle strobes for registers held outside the unit.
// Assumes the bus strobes are synchronous to clk. A write takes precedence
// over a read that overlaps it.
module uart_host_decode
    import dual_uart_regif_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic                    chan_sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NCH-1:0]          bank,
    output logic [CH_W-1:0]         ch_idx,
    output tgt_e                    tgt,
    output logic                    wr_go,
    output logic                    rd_live,
    output logic [NCH*(1<<ADDR_W)-1:0] ext_wr_stb,
    output logic [NCH*(1<<ADDR_W)-1:0] ext_rd_stb
);
    localparam int NREG = 1 << ADDR_W;

    logic wr_act, rd_act;
    logic wr_q, rd_q;
    logic rd_go;
    logic sel_bank;

    // Level of an active write, and of an active read with no write overlapping it
    assign wr_act  = !cs_n && !wr_n;
    assign rd_act  = !cs_n && !rd_n && wr_n;
    assign rd_live = rd_act;

    // Remember last cycle's activity to find the first cycle of each access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

    assign wr_go = wr_act && !wr_q;
    assign rd_go = rd_act && !rd_q;

    // Channel 1 lives at index 0, channel 2 at index 1
    assign ch_idx   = chan_sel ? CH_W'(0) : CH_W'(1);
    assign sel_bank = bank[ch_idx];

    // Map the address and the bank bit to a target register
    always_comb begin
        tgt = TGT_EXT;
        if (addr == ADDR_W'(ADDR_LINE))
            tgt = TGT_LINE;
        else if (sel_bank && addr == ADDR_W'(ADDR_LO))
            tgt = TGT_DLO;
        else if (sel_bank && addr == ADDR_W'(ADDR_HI))
            tgt = TGT_DHI;
        else if (sel_bank && addr == ADDR_W'(ADDR_FSEL))
            tgt = TGT_FSEL;
    end

    // One strobe bit per channel and address, for outside registers only
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            for (int a = 0; a < NREG; a++) begin
                ext_wr_stb[c*NREG+a] = wr_go && (tgt == TGT_EXT) &&
                                       (ch_idx == CH_W'(c)) && (addr == ADDR_W'(a));
                ext_rd_stb[c*NREG+a] = rd_go && (tgt == TGT_EXT) &&
                                       (ch_idx == CH_W'(c)) && (addr == ADDR_W'(a));
            end
        end
    end
endmodule

// File: rtl/uart_chan_regs.sv
// Module: register bank of one channel.
// Holds the line control byte, the two divisor bytes and the function-select byte.
// Reset clears the line control and function-select bytes but keeps the divisor.
// Assumes wr_en is already qualified with the channel and the first write cycle.
module uart_chan_regs
    import dual_uart_regif_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] line_q,
    output logic [DATA_W-1:0] fsel_q,
    output logic [DIV_W-1:0]  divisor,
    output logic              div_wr,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] dlo_q, dhi_q;

    // Control bytes: cleared by master reset, loaded by host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            fsel_q <= '0;
        end else if (wr_en) begin
            if (tgt == TGT_LINE) line_q <= wdata;
            if (tgt == TGT_FSEL) fsel_q <= wdata;
        end
    end

    // Divisor bytes: no reset, so they survive master reset
    always_ff @(posedge clk) begin
        if (wr_en && tgt == TGT_DLO) dlo_q <= wdata;
        if (wr_en && tgt == TGT_DHI) dhi_q <= wdata;
    end

    assign divisor = DIV_W'({dhi_q, dlo_q});
    assign div_wr  = wr_en && (tgt == TGT_DLO || tgt == TGT_DHI);

    // Read value of the register held here, for the decoded target
    always_comb begin
        case (tgt)
            TGT_LINE: rd_val = line_q;
            TGT_DLO:  rd_val = dlo_q;
            TGT_DHI:  rd_val = dhi_q;
            TGT_FSEL: rd_val = fsel_q;
            default:  rd_val = '0;
        endcase
    end
endmodule

// File: rtl/uart_baud_gen.sv
// Module: baud pulse generator for one channel.
// It counts clk cycles and emits a one-cycle pulse every `divisor` cycles.
// A divisor of 0 gives no pulse, and a divisor of 1 holds the output high.
// A restart (divisor write) sets the count back to zero.
module uart_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == divisor - 1'b1);
    assign tick = (divisor != '0) && last;

    // Count up to divisor-1 and wrap, or restart on a divisor write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/uart_mf_mux.sv
// Module: multi-function pin selector for one channel.
// It picks OUT2, the baud pulse or receive-ready from a two-bit code.
// The unused code 11 falls back to OUT2. Purely combinational.
module uart_mf_mux
    import dual_uart_regif_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       out2_n,
    input  logic       baud,
    input  logic       rxrdy_n,
    output logic       pin
);
    // Route the selected source to the pin
    always_comb begin
        case (mf_sel_e'(sel))
            MF_BAUD:  pin = baud;
            MF_RXRDY: pin = rxrdy_n;
            default:  pin = out2_n;
        endcase
    end
endmodule

// File: rtl/dual_uart_regif.sv
// Module: host register unit of a two-channel serial controller (top).
// It decodes host accesses, keeps the per-channel line control, divisor and
// function-select bytes, and forwards strobes and read data for outside
// registers. It also produces each channel's baud pulse and multi-function pin.
// Assumes host strobes are synchronous to clk and the reset is synchronous.
module dual_uart_regif
    import dual_uart_regif_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int DIV_W  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cs_n,
    input  logic                                  rd_n,
    input  logic                                  wr_n,
    input  logic                                  chan_sel,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [DATA_W-1:0]                     wdata,
    output logic [DATA_W-1:0]                     rdata,
    input  logic [NCH*(1<<ADDR_W)*DATA_W-1:0]     ext_rdata,
    output logic [NCH*(1<<ADDR_W)-1:0]            ext_wr_stb,
    output logic [NCH*(1<<ADDR_W)-1:0]            ext_rd_stb,
    input  logic [NCH-1:0]                        out2_n,
    input  logic [NCH-1:0]                        rxrdy_n,
    output logic [NCH*DATA_W-1:0]                 lcr_q,
    output logic [NCH-1:0]                        baud16,
    output logic [NCH-1:0]                        mf
);
    localparam int NREG  = 1 << ADDR_W;
    localparam int SEL_W = CH_W + ADDR_W;

    logic [CH_W-1:0]           ch_idx;
    tgt_e                      tgt;
    logic                      wr_go;
    logic                      rd_live;
    logic [NCH-1:0]            bank;
    logic [NCH-1:0]            div_wr;
    logic [NCH*2-1:0]          mf_sel_w;
    logic [NCH*DIV_W-1:0]      div_w;
    logic [DATA_W-1:0]         chan_rd [NCH];
    logic [DATA_W-1:0]         ext_val;
    logic [SEL_W-1:0]          ext_sel;

    uart_host_decode #(.ADDR_W(ADDR_W)) dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .chan_sel   (chan_sel),
        .addr       (addr),
        .bank       (bank),
        .ch_idx     (ch_idx),
        .tgt        (tgt),
        .wr_go      (wr_go),
        .rd_live    (rd_live),
        .ext_wr_stb (ext_wr_stb),
        .ext_rd_stb (ext_rd_stb)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DATA_W-1:0] line_c, fsel_c;
        logic [DIV_W-1:0]  div_c;
        logic              tick_c;

        uart_chan_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) regs_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_go && ch_idx == CH_W'(c)),
            .tgt     (tgt),
            .wdata   (wdata),
            .line_q  (line_c),
            .fsel_q  (fsel_c),
            .divisor (div_c),
            .div_wr  (div_wr[c]),
            .rd_val  (chan_rd[c])
        );

        uart_baud_gen #(.DIV_W(DIV_W)) baud_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (div_wr[c]),
            .divisor (div_c),
            .tick    (tick_c)
        );

        uart_mf_mux mux_i (
            .sel     (fsel_c[FSEL_LSB +: 2]),
            .out2_n  (out2_n[c]),
            .baud    (tick_c),
            .rxrdy_n (rxrdy_n[c]),
            .pin     (mf[c])
        );

        assign bank[c]                    = line_c[BANK_BIT];
        assign lcr_q[c*DATA_W +: DATA_W]  = line_c;
        assign baud16[c]                  = tick_c;
        assign mf_sel_w[c*2 +: 2]         = fsel_c[FSEL_LSB +: 2];
        assign div_w[c*DIV_W +: DIV_W]    = div_c;
    end

    assign ext_sel = {ch_idx, addr};

    // Pick the outside register byte addressed by channel and address
    always_comb begin
        ext_val = '0;
        for (int k = 0; k < NCH*NREG; k++)
            if (ext_sel == SEL_W'(k)) ext_val = ext_rdata[k*DATA_W +: DATA_W];
    end

    // Read data: outside or local value during a valid read, else zero
    always_comb begin
        if (!rd_live)
            rdata = '0;
        else if (tgt == TGT_EXT)
            rdata = ext_val;
        else
            rdata = chan_rd[ch_idx];
    end
endmodule

// File: rtl/dual_uart_regif_chk.sv
// Module: assertion checker bound to dual_uart_regif.
// It watches the host port, the strobes, the pin selection and the baud output.
module dual_uart_regif_chk #(
    parameter int NCH    = 2,
    parameter int NREG   = 8,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_n,
    input logic                   rd_n,
    input logic                   wr_n,
    input logic [DATA_W-1:0]      rdata,
    input logic [NCH*NREG-1:0]    ext_wr_stb,
    input logic [NCH*NREG-1:0]    ext_rd_stb,
    input logic [NCH-1:0]         out2_n,
    input logic [NCH-1:0]         rxrdy_n,
    input logic [NCH-1:0]         baud16,
    input logic [NCH-1:0]         mf,
    input logic [NCH*2-1:0]       mf_sel,
    input logic [NCH*DIV_W-1:0]   divisor
);
    a_r3_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> rdata == '0);

    a_r3_no_strobe_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (ext_wr_stb == '0 && ext_rd_stb == '0));

    a_r4_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_wr_stb, ext_rd_stb}));

    a_r4_wr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_wr_stb != '0) |=> (ext_wr_stb == '0));

    a_r4_rd_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd_stb != '0) |=> (ext_rd_stb == '0));

    a_r5_overlap_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && !wr_n) |-> (rdata == '0 && ext_rd_stb == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        a_r6_mf_out2: assert property (@(posedge clk) disable iff (!rst_n)
            (mf_sel[c*2 +: 2] == 2'b00 || mf_sel[c*2 +: 2] == 2'b11) |-> mf[c] == out2_n[c]);

        a_r6_mf_baud: assert property (@(posedge clk) disable iff (!rst_n)
            (mf_sel[c*2 +: 2] == 2'b01) |-> mf[c] == baud16[c]);

        a_r6_mf_rxrdy: assert property (@(posedge clk) disable iff (!rst_n)
            (mf_sel[c*2 +: 2] == 2'b10) |-> mf[c] == rxrdy_n[c]);

        a_r8_div_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (divisor[c*DIV_W +: DIV_W] == '0) |-> !baud16[c]);

        a_r8_div_one_high: assert property (@(posedge clk) disable iff (!rst_n)
            (divisor[c*DIV_W +: DIV_W] == DIV_W'(1)) |-> baud16[c]);
    end
endmodule

bind dual_uart_regif dual_uart_regif_chk #(
    .NCH(2), .NREG(1 << ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .rdata      (rdata),
    .ext_wr_stb (ext_wr_stb),
    .ext_rd_stb (ext_rd_stb),
    .out2_n     (out2_n),
    .rxrdy_n    (rxrdy_n),
    .baud16     (baud16),
    .mf         (mf),
    .mf_sel     (mf_sel_w),
    .divisor    (div_w)
);

// File: tb/dual_uart_regif_tb_top.sv
// Bench for dual_uart_regif. Driver tasks push expected read values into a
// queue, and a monitor pops and compares them against rdata.
module dual_uart_regif_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         cs_n, rd_n, wr_n, chan_sel;
    logic [2:0]   addr;
    logic [7:0]   wdata;
    logic [7:0]   rdata;
    logic [127:0] ext_rdata;
    logic [15:0]  ext_wr_stb, ext_rd_stb;
    logic [1:0]   out2_n, rxrdy_n;
    logic [15:0]  lcr_q;
    logic [1:0]   baud16, mf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct { logic [7:0] exp; string tag; } sb_item_t;
    sb_item_t sb_q[$];
    bit mon_req = 1'b0;
    logic [15:0] seen_wr, seen_rd;

    always #5 clk = ~clk;

    dual_uart_regif dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .chan_sel(chan_sel), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ext_rdata(ext_rdata), .ext_wr_stb(ext_wr_stb), .ext_rd_stb(ext_rd_stb),
        .out2_n(out2_n), .rxrdy_n(rxrdy_n), .lcr_q(lcr_q), .baud16(baud16), .mf(mf)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop the expected read value and compare it with rdata
    always @(negedge clk) begin
        if (mon_req) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(rdata === it.exp, it.tag, 32'(rdata), 32'(it.exp));
            mon_req = 1'b0;
        end
    end

    task automatic bus_wr(input bit ch1, input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        chan_sel = ch1; addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); seen_wr = ext_wr_stb;
        @(posedge clk); #1;
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_rd(input bit ch1, input logic [2:0] a, input logic [7:0] e,
                          input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        chan_sel = ch1; addr = a; cs_n = 1'b0; rd_n = 1'b0;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        mon_req = 1'b1;
        @(negedge clk); seen_rd = ext_rd_stb;
        @(posedge clk); #1;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        int hits;
        int first;
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; chan_sel = 1'b1;
        addr = '0; wdata = '0; out2_n = 2'b01; rxrdy_n = 2'b11; rst_n = 1'b0;
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 8; a++)
                ext_rdata[(c*8+a)*8 +: 8] = 8'(8'h40 + c*8 + a);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(rdata == 8'h00, "R3 reset rdata", 32'(rdata), 0);
        check(mf == out2_n, "R7 reset mf shows out2", 32'(mf), 32'(out2_n));

        // R2: bank in, program channel 1 divisor 3 and pin source baud
        bus_wr(1, 3, 8'h80);
        check(seen_wr == 0, "R4 no strobe on line byte", 32'(seen_wr), 0);
        bus_wr(1, 1, 8'h00);
        bus_wr(1, 2, 8'h02);
        check(seen_wr == 0, "R4 no strobe on fsel", 32'(seen_wr), 0);
        bus_rd(1, 2, 8'h02, "R2 fsel readback");
        bus_rd(1, 1, 8'h00, "R2 divisor high readback");
        bus_wr(1, 0, 8'h03);
        // R8: divisor write at this edge, first pulse in the 3rd cycle
        hits = 0; first = 0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (baud16[0]) begin hits++; if (first == 0) first = i; end
            check(mf[0] == baud16[0], "R6 mf follows baud", 32'(mf[0]), 32'(baud16[0]));
        end
        check(hits == 10, "R8 pulse count divisor 3", hits, 10);
        check(first == 3, "R8 first pulse after restart", first, 3);
        bus_rd(1, 0, 8'h03, "R2 divisor low readback");
        check(seen_rd == 0, "R4 no read strobe for divisor", 32'(seen_rd), 0);

        // R2: bank out, addresses 0..2 reach outside registers
        bus_wr(1, 3, 8'h03);
        bus_rd(1, 3, 8'h03, "R2 line byte readback");
        bus_rd(1, 0, 8'h40, "R2 outside reg at addr 0");
        check(seen_rd == 16'h0001, "R4 read strobe ch1 addr0", 32'(seen_rd), 1);

        // R1: channel 2 setup, divisor 1, pin source receive-ready
        bus_wr(0, 3, 8'h80);
        bus_wr(0, 0, 8'h01);
        bus_wr(0, 1, 8'h00);
        bus_wr(0, 2, 8'h04);
        bus_rd(0, 3, 8'h80, "R1 ch2 line byte");
        bus_rd(1, 3, 8'h03, "R1 ch1 untouched by ch2 writes");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(baud16[1] == 1'b1, "R8 divisor 1 holds high", 32'(baud16[1]), 1);
        end
        rxrdy_n = 2'b10; #1;
        check(mf[1] == 1'b1, "R6 mf rxrdy high", 32'(mf[1]), 1);
        rxrdy_n = 2'b00; #1;
        check(mf[1] == 1'b0, "R6 mf rxrdy low", 32'(mf[1]), 0);
        bus_wr(0, 2, 8'h06);
        out2_n = 2'b01; #1;
        check(mf[1] == 1'b0, "R6 code 11 gives out2 low", 32'(mf[1]), 0);
        out2_n = 2'b11; #1;
        check(mf[1] == 1'b1, "R6 code 11 gives out2 high", 32'(mf[1]), 1);
        bus_wr(0, 0, 8'h00);
        hits = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (baud16[1]) hits++;
        end
        check(hits == 0, "R8 divisor 0 quiet", hits, 0);

        // R4: strobes for outside registers on channel 2
        bus_wr(0, 3, 8'h00);
        bus_wr(0, 7, 8'h55);
        check(seen_wr == 16'h8000, "R4 write strobe ch2 addr7", 32'(seen_wr), 32'h8000);
        bus_rd(0, 5, 8'h4D, "R4 outside read ch2 addr5");
        check(seen_rd == 16'h2000, "R4 read strobe ch2 addr5", 32'(seen_rd), 32'h2000);

        // R3: no chip select means no read data and no write
        @(posedge clk); #1;
        chan_sel = 1; addr = 3; wdata = 8'hFF; rd_n = 1'b0;
        @(negedge clk);
        check(rdata == 8'h00, "R3 rdata zero without cs", 32'(rdata), 0);
        check(ext_rd_stb == 0, "R3 no read strobe without cs", 32'(ext_rd_stb), 0);
        @(posedge clk); #1;
        rd_n = 1'b1; wr_n = 1'b0;
        @(posedge clk); #1;
        wr_n = 1'b1;
        bus_rd(1, 3, 8'h03, "R3 write ignored without cs");

        // R5: read and write overlap on the line byte
        @(posedge clk); #1;
        chan_sel = 1; addr = 3; wdata = 8'h1B; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        check(rdata == 8'h00, "R5 overlap rdata zero", 32'(rdata), 0);
        check(ext_rd_stb == 0, "R5 overlap no read strobe", 32'(ext_rd_stb), 0);
        @(posedge clk); #1;
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        bus_rd(1, 3, 8'h1B, "R5 overlap write taken");

        // R4: a held write raises one strobe only
        @(posedge clk); #1;
        chan_sel = 1; addr = 7; wdata = 8'h11; cs_n = 1'b0; wr_n = 1'b0;
        hits = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ext_wr_stb != 0) hits++;
        end
        @(posedge clk); #1;
        cs_n = 1'b1; wr_n = 1'b1;
        check(hits == 1, "R4 held write single strobe", hits, 1);

        // R7: reset clears line and fsel, keeps divisor
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        out2_n = 2'b10; #1;
        check(mf[0] == out2_n[0], "R7 mf back to out2", 32'(mf[0]), 32'(out2_n[0]));
        bus_rd(1, 3, 8'h00, "R7 line byte cleared");
        bus_wr(1, 3, 8'h80);
        bus_rd(1, 0, 8'h03, "R7 divisor low kept");
        bus_rd(1, 2, 8'h00, "R7 fsel cleared");

        repeat (2) @(posedge clk);
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule